// File: doc/BRIEF.md
# Serial PHY Management Master with Link Poller

This block is the master side of a two-wire PHY management bus: one clock line and one bidirectional data line, shared by up to two PHYs. The management clock is divided down from the system clock by a programmable amount. Software-side logic requests a single register read or write by presenting a command and pulsing a go strobe. A busy flag (the go bit) stays high until the frame is complete. Completion is signalled by a raw interrupt flag, and a mask register gates that flag onto the interrupt output.

While no user command is pending, the block polls the link state of every enabled PHY slot in turn. It reads register 1 of each one and takes bit 2 of the returned word as the link state. Every acknowledged read sets that PHY's bit in a 32-entry alive map. Each acknowledged poll writes the link bit of that PHY into a 32-entry link map. A link-change interrupt is raised only for the PHY whose address equals the monitored address, and only while link interrupts are enabled.

The control state machine has three states. CS_IDLE moves to CS_USER when the go bit is set. Otherwise it moves to CS_POLL when polling is enabled and a slot is enabled. CS_USER and CS_POLL both return to CS_IDLE on frame done.

The frame engine has four states. FS_IDLE moves to FS_ARM on start. FS_ARM moves to FS_SHIFT on the next falling tick of the management clock. FS_SHIFT moves to FS_DONE on the falling tick that ends bit 63. FS_DONE always returns to FS_IDLE.

Top module: `mgmt_serial_master`

## Requirements
- R1: The management clock `mdc` resets low. Each of its high and low phases lasts `clk_div`+1 system clocks, so one period is 2*(`clk_div`+1) clocks.
- R2: Each frame is 64 bits, most significant first. It is made of 32 preamble ones, start 01, opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register address, turnaround (10 on writes, released on reads), then 16 data bits.
- R3: `mdio_o` and `mdio_oe` change only in the cycle where `mdc` falls. On a read the master releases the line (`mdio_oe`=0) from turnaround bit 46 through the last data bit. Input is sampled where `mdc` rises.
- R4: A `cmd_go` pulse while `go_busy` is low captures the command and raises `go_busy` on the next cycle. A `cmd_go` while `go_busy` is high is ignored. `go_busy` falls when the user frame completes.
- R5: On a user read, `rd_ack` is 1 only when the PHY drove the second turnaround bit low. `rd_data` holds the 16 data bits. Both update in the cycle `go_busy` falls. A read with no PHY reports `rd_ack`=0.
- R6: Bit A of `alive_map` is set when a read (user or poll) addressed to PHY A is acknowledged. A bit is cleared only by a 1 in the same position of `alive_clr`. All bits reset to 0.
- R7: `uint_raw` sets when a user command completes and clears on `uint_ack`. The mask sets on `umask_set`, clears on `umask_clr`, and resets to 0. `uint_out` = `uint_raw` AND mask.
- R8: Polling reads register 1 of each enabled slot in round-robin order. On acknowledge, bit 2 of the returned data is written to `link_map` at that PHY's address. Slot k uses address `slot_addr[5k+4:5k]`.
- R9: `link_int` sets only when an acknowledged poll changes the link bit of the PHY whose address equals `mon_addr` while `link_int_en` is 1. It clears on `link_int_ack`.
- R10: A pending user command is started at the next frame boundary, ahead of any further poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Management clock divider |
| poll_en | input | 1 | Enables link polling |
| slot_en | input | NUM_SLOT | Per-slot poll enable |
| slot_addr | input | 5*NUM_SLOT | PHY address of each slot |
| mon_addr | input | 5 | Monitored PHY address for link interrupt |
| link_int_en | input | 1 | Link interrupt enable |
| cmd_go | input | 1 | Go strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | 5 | Command PHY address |
| cmd_reg | input | 5 | Command register address |
| cmd_wdata | input | 16 | Write data |
| go_busy | output | 1 | Go bit, high while a user command is outstanding |
| rd_data | output | 16 | Last user read data |
| rd_ack | output | 1 | Last user read acknowledge |
| alive_map | output | 32 | Acknowledged-PHY bitmap |
| alive_clr | input | 32 | Write-one-to-clear for alive_map |
| link_map | output | 32 | Polled link bitmap |
| uint_raw | output | 1 | Raw user-complete flag |
| uint_ack | input | 1 | Clears uint_raw |
| umask_set | input | 1 | Sets user interrupt mask |
| umask_clr | input | 1 | Clears user interrupt mask |
| uint_out | output | 1 | Masked user-complete interrupt |
| link_int | output | 1 | Link-change interrupt |
| link_int_ack | input | 1 | Clears link_int |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data out |
| mdio_oe | output | 1 | Data output enable |
| mdio_i | input | 1 | Data in (line value) |

## Verification
The assertions assume that `clk_div` holds steady for the length of a clock phase. They also assume that the PHY changes `mdio_i` only after a falling edge of `mdc`, and that no clear or acknowledge input is driven together with the event it would race. The stimulus changes `clk_div` only once, before any frame starts, and it only drives the status inputs when no frame is completing. Its PHY responder drives the line from the `mdc` falling edge. Polling is switched off before the alive map is cleared, so that a poll cannot set the bit again in the same cycle.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DAT_W     = 16;
    localparam int MAP_W     = 1 << PHY_W;
    localparam int PRE_BITS  = 32;
    localparam int FRM_BITS  = 64;
    localparam int POS_W     = $clog2(FRM_BITS);
    localparam int TA_FIRST  = 46;
    localparam int TA_ACK    = 47;
    localparam int DATA_BASE = 48;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [REG_W-1:0] LINK_REG = 5'd1;
    localparam int LINK_BIT  = 2;

    typedef enum logic [1:0] {FS_IDLE, FS_ARM, FS_SHIFT, FS_DONE} frame_state_t;
    typedef enum logic [1:0] {CS_IDLE, CS_USER, CS_POLL} ctl_state_t;

    typedef struct packed {
        logic             wr;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic [DAT_W-1:0] wdata;
    } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_clkgen.sv
module mgmt_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             fall_tick,
    output logic             rise_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = (cnt_q >= div);
    assign fall_tick = wrap & mdc;
    assign rise_tick = wrap & ~mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
    import mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_tick,
    input  logic             rise_tick,
    input  logic             start,
    input  mgmt_cmd_t        cmd,
    input  logic             mdio_i,
    output logic             done,
    output logic [DAT_W-1:0] rdata,
    output logic             ack,
    output logic             mdio_o,
    output logic             mdio_oe
);
    frame_state_t          st_q, st_nx;
    logic [FRM_BITS-1:0]   sh_q;
    logic [POS_W-1:0]      pos_q;
    logic                  is_rd_q;
    logic [FRM_BITS-1:0]   frame;
    logic [POS_W-1:0]      pos_inc;

    assign pos_inc = pos_q + 1'b1;
    assign frame = {{PRE_BITS{1'b1}}, 2'b01, (cmd.wr ? OP_WR : OP_RD),
                    cmd.phy, cmd.regad, (cmd.wr ? 2'b10 : 2'b00),
                    (cmd.wr ? cmd.wdata : {DAT_W{1'b0}})};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FS_IDLE:  if (start) st_nx = FS_ARM;
            FS_ARM:   if (fall_tick) st_nx = FS_SHIFT;
            FS_SHIFT: if (fall_tick && pos_q == POS_W'(FRM_BITS-1)) st_nx = FS_DONE;
            FS_DONE:  st_nx = FS_IDLE;
            default:  st_nx = FS_IDLE;
        endcase
    end

    assign done = (st_q == FS_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            pos_q   <= '0;
            is_rd_q <= 1'b0;
            rdata   <= '0;
            ack     <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            unique case (st_q)
                FS_IDLE: begin
                    if (start) begin
                        sh_q    <= frame;
                        pos_q   <= '0;
                        is_rd_q <= ~cmd.wr;
                        rdata   <= '0;
                        ack     <= 1'b0;
                    end
                end
                FS_ARM: begin
                    if (fall_tick) begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= sh_q[FRM_BITS-1];
                        sh_q    <= sh_q << 1;
                    end
                end
                FS_SHIFT: begin
                    if (rise_tick && is_rd_q) begin
                        if (pos_q == POS_W'(TA_ACK))
                            ack <= ~mdio_i;
                        if (pos_q >= POS_W'(DATA_BASE))
                            rdata <= {rdata[DAT_W-2:0], mdio_i};
                    end
                    if (fall_tick) begin
                        if (pos_q == POS_W'(FRM_BITS-1)) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                        end else begin
                            pos_q   <= pos_inc;
                            mdio_o  <= sh_q[FRM_BITS-1];
                            sh_q    <= sh_q << 1;
                            mdio_oe <= ~(is_rd_q && pos_inc >= POS_W'(TA_FIRST));
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mgmt_sequencer.sv
module mgmt_sequencer
    import mgmt_pkg::*;
#(
    parameter int NUM_SLOT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      poll_en,
    input  logic [NUM_SLOT-1:0]       slot_en,
    input  logic [NUM_SLOT*PHY_W-1:0] slot_addr,
    input  logic                      cmd_go,
    input  mgmt_cmd_t                 cmd_in,
    input  logic                      eng_done,
    input  logic [DAT_W-1:0]          eng_rdata,
    input  logic                      eng_ack,
    output logic                      go_busy,
    output logic [DAT_W-1:0]          rd_data,
    output logic                      rd_ack,
    output logic                      start,
    output mgmt_cmd_t                 cmd_out,
    output logic                      done_user,
    output logic                      done_poll,
    output logic [PHY_W-1:0]          done_addr
);
    localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;

    ctl_state_t       st_q, st_nx;
    mgmt_cmd_t        ucmd_q;
    logic [SLOT_W-1:0] last_q, nxt_slot;
    logic             any_slot;
    logic             want_poll;

    always_comb begin
        nxt_slot = last_q;
        any_slot = 1'b0;
        for (int k = 1; k <= NUM_SLOT; k++) begin
            if (!any_slot && slot_en[(int'(last_q) + k) % NUM_SLOT]) begin
                any_slot = 1'b1;
                nxt_slot = SLOT_W'((int'(last_q) + k) % NUM_SLOT);
            end
        end
    end

    assign want_poll = poll_en && any_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CS_IDLE: begin
                if (go_busy)        st_nx = CS_USER;
                else if (want_poll) st_nx = CS_POLL;
            end
            CS_USER: if (eng_done) st_nx = CS_IDLE;
            CS_POLL: if (eng_done) st_nx = CS_IDLE;
            default: st_nx = CS_IDLE;
        endcase
    end

    always_comb begin
        start     = (st_q == CS_IDLE) && (go_busy || want_poll);
        done_user = (st_q == CS_USER) && eng_done;
        done_poll = (st_q == CS_POLL) && eng_done;
        if (go_busy) begin
            cmd_out = ucmd_q;
        end else begin
            cmd_out.wr    = 1'b0;
            cmd_out.phy   = slot_addr[nxt_slot*PHY_W +: PHY_W];
            cmd_out.regad = LINK_REG;
            cmd_out.wdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_busy   <= 1'b0;
            ucmd_q    <= '0;
            last_q    <= '0;
            rd_data   <= '0;
            rd_ack    <= 1'b0;
            done_addr <= '0;
        end else begin
            if (cmd_go && !go_busy) begin
                go_busy <= 1'b1;
                ucmd_q  <= cmd_in;
            end else if (done_user) begin
                go_busy <= 1'b0;
                rd_data <= eng_rdata;
                rd_ack  <= eng_ack;
            end
            if (start) begin
                done_addr <= cmd_out.phy;
                if (!go_busy) last_q <= nxt_slot;
            end
        end
    end
endmodule

// File: rtl/mgmt_status.sv
module mgmt_status
    import mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_user,
    input  logic             done_poll,
    input  logic [PHY_W-1:0] done_addr,
    input  logic             done_ack,
    input  logic             done_link,
    input  logic [MAP_W-1:0] alive_clr,
    input  logic             uint_ack,
    input  logic             umask_set,
    input  logic             umask_clr,
    input  logic [PHY_W-1:0] mon_addr,
    input  logic             link_int_en,
    input  logic             link_int_ack,
    output logic [MAP_W-1:0] alive_map,
    output logic [MAP_W-1:0] link_map,
    output logic             uint_raw,
    output logic             uint_out,
    output logic             link_int
);
    logic [MAP_W-1:0] hit_vec;
    logic             poll_ok;
    logic             link_moved;
    logic             mask_q;

    assign hit_vec    = ((done_user || done_poll) && done_ack) ? (MAP_W'(1) << done_addr) : '0;
    assign poll_ok    = done_poll && done_ack;
    assign link_moved = poll_ok && (link_map[done_addr] != done_link);
    assign uint_out   = uint_raw & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alive_map <= '0;
            link_map  <= '0;
            uint_raw  <= 1'b0;
            mask_q    <= 1'b0;
            link_int  <= 1'b0;
        end else begin
            alive_map <= (alive_map & ~alive_clr) | hit_vec;
            if (poll_ok) link_map[done_addr] <= done_link;
            if (done_user)     uint_raw <= 1'b1;
            else if (uint_ack) uint_raw <= 1'b0;
            if (umask_set)      mask_q <= 1'b1;
            else if (umask_clr) mask_q <= 1'b0;
            if (link_moved && link_int_en && done_addr == mon_addr) link_int <= 1'b1;
            else if (link_int_ack)                                  link_int <= 1'b0;
        end
    end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int NUM_SLOT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIV_W-1:0]          clk_div,
    input  logic                      poll_en,
    input  logic [NUM_SLOT-1:0]       slot_en,
    input  logic [NUM_SLOT*PHY_W-1:0] slot_addr,
    input  logic [PHY_W-1:0]          mon_addr,
    input  logic                      link_int_en,
    input  logic                      cmd_go,
    input  logic                      cmd_write,
    input  logic [PHY_W-1:0]          cmd_phy,
    input  logic [REG_W-1:0]          cmd_reg,
    input  logic [DAT_W-1:0]          cmd_wdata,
    output logic                      go_busy,
    output logic [DAT_W-1:0]          rd_data,
    output logic                      rd_ack,
    output logic [MAP_W-1:0]          alive_map,
    input  logic [MAP_W-1:0]          alive_clr,
    output logic [MAP_W-1:0]          link_map,
    output logic                      uint_raw,
    input  logic                      uint_ack,
    input  logic                      umask_set,
    input  logic                      umask_clr,
    output logic                      uint_out,
    output logic                      link_int,
    input  logic                      link_int_ack,
    output logic                      mdc,
    output logic                      mdio_o,
    output logic                      mdio_oe,
    input  logic                      mdio_i
);
    logic             fall_tick, rise_tick;
    logic             start, eng_done, eng_ack;
    logic [DAT_W-1:0] eng_rdata;
    mgmt_cmd_t        cmd_in, cmd_sel;
    logic             done_user, done_poll;
    logic [PHY_W-1:0] done_addr;

    assign cmd_in = '{wr: cmd_write, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};

    mgmt_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .div(clk_div),
        .mdc(mdc), .fall_tick(fall_tick), .rise_tick(rise_tick)
    );

    mgmt_sequencer #(.NUM_SLOT(NUM_SLOT)) u_seq (
        .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .slot_en(slot_en),
        .slot_addr(slot_addr), .cmd_go(cmd_go), .cmd_in(cmd_in),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .eng_ack(eng_ack),
        .go_busy(go_busy), .rd_data(rd_data), .rd_ack(rd_ack),
        .start(start), .cmd_out(cmd_sel), .done_user(done_user),
        .done_poll(done_poll), .done_addr(done_addr)
    );

    mgmt_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .rise_tick(rise_tick),
        .start(start), .cmd(cmd_sel), .mdio_i(mdio_i), .done(eng_done),
        .rdata(eng_rdata), .ack(eng_ack), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    mgmt_status u_stat (
        .clk(clk), .rst_n(rst_n), .done_user(done_user), .done_poll(done_poll),
        .done_addr(done_addr), .done_ack(eng_ack), .done_link(eng_rdata[LINK_BIT]),
        .alive_clr(alive_clr), .uint_ack(uint_ack), .umask_set(umask_set),
        .umask_clr(umask_clr), .mon_addr(mon_addr), .link_int_en(link_int_en),
        .link_int_ack(link_int_ack), .alive_map(alive_map), .link_map(link_map),
        .uint_raw(uint_raw), .uint_out(uint_out), .link_int(link_int)
    );
endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] clk_div,
    input logic             cmd_go,
    input logic             go_busy,
    input logic             rd_ack,
    input logic [31:0]      alive_map,
    input logic [31:0]      alive_clr,
    input logic             uint_raw,
    input logic             link_int,
    input logic             link_int_en,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    logic             mdc_d, seen_q, div_ok_q;
    logic [DIV_W:0]   ph_cnt;
    logic [DIV_W-1:0] div_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_d    <= 1'b0;
            seen_q   <= 1'b0;
            div_ok_q <= 1'b1;
            ph_cnt   <= '0;
            div_d    <= '0;
        end else begin
            mdc_d <= mdc;
            div_d <= clk_div;
            if (mdc != mdc_d) begin
                ph_cnt   <= '0;
                seen_q   <= 1'b1;
                div_ok_q <= 1'b1;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
                if (clk_div != div_d) div_ok_q <= 1'b0;
            end
        end
    end

    assert_phase_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != mdc_d && seen_q && div_ok_q && clk_div == div_d) |-> (ph_cnt == {1'b0, clk_div}));

    assert_drive_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $fell(mdc));

    assert_go_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !go_busy) |=> go_busy);

    assert_ack_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_ack) |-> $fell(go_busy));

    assert_alive_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alive_map) & ~alive_map & ~$past(alive_clr)) == 32'h0);

    assert_uint_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_busy) |-> uint_raw);

    assert_link_int_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_int) |-> $past(link_int_en));
endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_mgmt_serial_master.sv
module sim_mgmt_serial_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd3;
    logic        poll_en = 1'b0;
    logic [1:0]  slot_en = 2'b00;
    logic [9:0]  slot_addr = 10'd0;
    logic [4:0]  mon_addr = 5'd0;
    logic        link_int_en = 1'b0;
    logic        cmd_go = 1'b0, cmd_write = 1'b0;
    logic [4:0]  cmd_phy = 5'd0, cmd_reg = 5'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic [31:0] alive_clr = 32'd0;
    logic        uint_ack = 1'b0, umask_set = 1'b0, umask_clr = 1'b0, link_int_ack = 1'b0;
    logic        go_busy, rd_ack, uint_raw, uint_out, link_int, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic [31:0] alive_map, link_map;
    logic        phy_oe = 1'b0, phy_do = 1'b1;
    wire         mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_do : 1'b1);

    always #4 clk = ~clk;

    mgmt_serial_master u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .poll_en(poll_en), .slot_en(slot_en),
        .slot_addr(slot_addr), .mon_addr(mon_addr), .link_int_en(link_int_en),
        .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .go_busy(go_busy), .rd_data(rd_data), .rd_ack(rd_ack),
        .alive_map(alive_map), .alive_clr(alive_clr), .link_map(link_map),
        .uint_raw(uint_raw), .uint_ack(uint_ack), .umask_set(umask_set),
        .umask_clr(umask_clr), .uint_out(uint_out), .link_int(link_int),
        .link_int_ack(link_int_ack), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_line)
    );

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---- PHY responder: PHYs at addresses 3 and 9 ----
    localparam logic [4:0] PA = 5'd3, PB = 5'd9;
    logic [15:0] rfa [32];
    logic [15:0] rfb [32];
    int pos = -1, ones = 0;
    bit pre_seen = 0, rd_act = 0;
    logic [31:0] fb;
    logic [1:0]  f_op;
    logic [4:0]  f_ph, f_rg;
    bit          f_st;
    logic [15:0] rdv;
    int lg_op[$], lg_phy[$], lg_reg[$], lg_dat[$], lg_ok[$];

    function automatic bit present(input logic [4:0] a);
        return (a == PA) || (a == PB);
    endfunction

    always @(posedge mdc) begin
        if (pos < 0) begin
            if (mdio_line) ones = ones + 1;
            else begin pre_seen = (ones >= 32); ones = 0; pos = 32; fb = 32'd0; end
        end else begin
            pos = pos + 1;
            fb = {fb[30:0], mdio_line};
            if (pos == 45) begin
                f_st = (fb[13:12] == 2'b01);
                f_op = fb[11:10]; f_ph = fb[9:5]; f_rg = fb[4:0];
                rd_act = (f_op == 2'b10) && present(f_ph);
                rdv = (f_ph == PA) ? rfa[f_rg] : rfb[f_rg];
            end
            if (pos == 63) begin
                if (f_op == 2'b01 && f_ph == PA) rfa[f_rg] = fb[15:0];
                if (f_op == 2'b01 && f_ph == PB) rfb[f_rg] = fb[15:0];
                lg_op.push_back(int'(f_op)); lg_phy.push_back(int'(f_ph));
                lg_reg.push_back(int'(f_rg)); lg_dat.push_back(int'(fb[15:0]));
                lg_ok.push_back(int'(pre_seen && f_st));
                pos = -1; rd_act = 0;
            end
        end
    end

    always @(negedge mdc) begin
        if (rd_act && pos >= 46 && pos < 63) begin
            phy_oe <= 1'b1;
            phy_do <= (pos + 1 == 47) ? 1'b0 : rdv[63 - (pos + 1)];
        end else begin
            phy_oe <= 1'b0;
        end
    end

    // ---- per-clock reference model ----
    int  m_cnt = 0;
    bit  m_mdc = 0, m_mask = 0;
    logic p_o = 0, p_oe = 0, p_mdc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin m_cnt = 0; m_mdc = 0; m_mask = 0; end
        else begin
            if (m_cnt >= int'(clk_div)) begin m_cnt = 0; m_mdc = ~m_mdc; end
            else m_cnt = m_cnt + 1;
            if (umask_set) m_mask = 1; else if (umask_clr) m_mask = 0;
        end
    end
    always @(negedge clk) begin
        if (rst_n) begin
            chk(mdc == m_mdc, "R1 mdc", {31'd0, mdc}, {31'd0, m_mdc});
            chk(uint_out == (uint_raw & m_mask), "R7 masked irq", {31'd0, uint_out}, {31'd0, uint_raw & m_mask});
            if (mdio_o != p_o || mdio_oe != p_oe)
                chk(p_mdc && !mdc, "R3 drive only on fall", {31'd0, mdc}, 32'd0);
        end
        p_o = mdio_o; p_oe = mdio_oe; p_mdc = mdc;
    end

    task automatic pulse_go(input bit wr, input logic [4:0] ph, input logic [4:0] rg, input logic [15:0] wd);
        @(negedge clk);
        cmd_write = wr; cmd_phy = ph; cmd_reg = rg; cmd_wdata = wd; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_idle();
        while (go_busy) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int n0;
        int k;
        for (int i = 0; i < 32; i++) begin rfa[i] = 16'h0; rfb[i] = 16'h0; end
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(go_busy == 0, "R4 reset go", {31'd0, go_busy}, 0);
        chk(alive_map == 0, "R6 reset alive", alive_map, 0);
        chk(link_map == 0, "R8 reset link", link_map, 0);
        chk(uint_raw == 0, "R7 reset raw", {31'd0, uint_raw}, 0);
        chk(link_int == 0, "R9 reset link_int", {31'd0, link_int}, 0);
        chk(mdio_oe == 0, "R3 reset oe", {31'd0, mdio_oe}, 0);
        idle(40);                      // R1: divider 3 observed per clock
        clk_div = 8'd1;
        idle(10);

        // R2/R4: write, plus a go ignored while busy
        pulse_go(1'b1, PA, 5'd5, 16'hA5C3);
        chk(go_busy == 1, "R4 go set", {31'd0, go_busy}, 1);
        idle(20);
        pulse_go(1'b1, PB, 5'd7, 16'h1234);
        wait_idle();
        chk(lg_op.size() == 1, "R2 one frame", lg_op.size(), 1);
        chk(lg_op[0] == 1 && lg_phy[0] == 3 && lg_reg[0] == 5, "R2 write header",
            {lg_op[0][7:0], lg_phy[0][7:0], lg_reg[0][15:0]}, 32'h0103_0005);
        chk(lg_dat[0] == 32'hA5C3, "R2 write data", lg_dat[0], 32'hA5C3);
        chk(lg_ok[0] == 1, "R2 preamble/start", lg_ok[0], 1);
        chk(uint_raw == 1, "R7 raw on done", {31'd0, uint_raw}, 1);
        idle(400);
        chk(lg_op.size() == 1 && rfb[7] == 16'h0, "R4 go while busy ignored", lg_op.size(), 1);
        chk(go_busy == 0, "R4 stays clear", {31'd0, go_busy}, 0);

        // R5: acknowledged read
        pulse_go(1'b0, PA, 5'd5, 16'h0);
        wait_idle();
        chk(rd_data == 16'hA5C3, "R5 read data", rd_data, 16'hA5C3);
        chk(rd_ack == 1, "R5 read ack", {31'd0, rd_ack}, 1);
        chk(alive_map[3] == 1, "R6 alive set", alive_map, 32'h8);
        chk(lg_op[1] == 2 && lg_ok[1] == 1, "R2 read opcode", lg_op[1], 2);

        // R5: absent PHY
        pulse_go(1'b0, 5'd20, 5'd2, 16'h0);
        wait_idle();
        chk(rd_ack == 0, "R5 no ack", {31'd0, rd_ack}, 0);
        chk(alive_map[20] == 0, "R6 no alive on nack", alive_map, 32'h8);

        // R7: mask and ack
        uint_ack = 1; @(negedge clk); uint_ack = 0;
        chk(uint_raw == 0, "R7 raw cleared", {31'd0, uint_raw}, 0);
        umask_set = 1; @(negedge clk); umask_set = 0;
        pulse_go(1'b0, PB, 5'd0, 16'h0);
        wait_idle();
        chk(uint_out == 1, "R7 masked on", {31'd0, uint_out}, 1);
        umask_clr = 1; @(negedge clk); umask_clr = 0;
        chk(uint_out == 0 && uint_raw == 1, "R7 masked off", {31'd0, uint_out}, 0);

        // R8/R9: polling
        rfb[1] = 16'h0004; rfa[1] = 16'h0000;
        slot_addr = {PB, PA}; slot_en = 2'b11; mon_addr = PB; link_int_en = 1;
        n0 = lg_op.size();
        poll_en = 1;
        k = 0;
        while (!link_map[9] && k < 5000) begin @(negedge clk); k++; end
        @(negedge clk);
        chk(link_map[9] == 1, "R8 link up seen", link_map, 32'h200);
        chk(link_int == 1, "R9 link int monitored", {31'd0, link_int}, 1);
        chk(alive_map[9] == 1, "R6 alive by poll", alive_map, 32'h208);
        while (lg_op.size() < n0 + 4) @(negedge clk);
        for (int i = n0; i < n0 + 4; i++) begin
            chk(lg_op[i] == 2 && lg_reg[i] == 1, "R8 poll reads reg 1", lg_reg[i], 1);
            if (i > n0) chk(lg_phy[i] != lg_phy[i-1], "R8 round robin", lg_phy[i], lg_phy[i-1]);
        end
        link_int_ack = 1; @(negedge clk); link_int_ack = 0;
        chk(link_int == 0, "R9 ack clears", {31'd0, link_int}, 0);
        rfa[1] = 16'h0004;
        k = 0;
        while (!link_map[3] && k < 5000) begin @(negedge clk); k++; end
        idle(600);
        chk(link_map[3] == 1, "R8 second slot link", link_map, 32'h208);
        chk(link_int == 0, "R9 unmonitored change", {31'd0, link_int}, 0);
        link_int_en = 0; rfb[1] = 16'h0;
        k = 0;
        while (link_map[9] && k < 5000) begin @(negedge clk); k++; end
        idle(2);
        chk(link_map[9] == 0, "R8 link down seen", link_map, 32'h8);
        chk(link_int == 0, "R9 disabled", {31'd0, link_int}, 0);

        // R10: user priority
        n0 = lg_op.size();
        pulse_go(1'b1, PA, 5'd6, 16'h0F0F);
        wait_idle();
        k = -1;
        for (int i = n0; i < lg_op.size(); i++) if (lg_op[i] == 1) k = i;
        chk(k >= n0 && k <= n0 + 1, "R10 user at next boundary", k, n0 + 1);
        chk(rfa[6] == 16'h0F0F, "R2 write landed", rfa[6], 16'h0F0F);

        // R6: write-one-to-clear
        poll_en = 0;
        idle(400);
        alive_clr = 32'h8; @(negedge clk); alive_clr = 0;
        @(negedge clk);
        chk(alive_map[3] == 0 && alive_map[9] == 1, "R6 w1c", alive_map, 32'h200);

        finished = 1;
        summary();
        $finish;
    end
endmodule